// File: doc/BRIEF.md
# Compare-and-Branch Instruction Fuser

This block sits ahead of the instruction decoders. Pre-decoded instruction records arrive on a valid/ready stream. Each record carries an operation class, three register fields, a memory-operand flag, a condition code, a target/displacement field and an end-of-stream flag. The block looks at each adjacent pair of records. A compare followed at once by a conditional jump becomes one compare-and-branch operation. A memory load whose result feeds the first source of the next add becomes one load-add operation. Fusing these pairs sends fewer operations down the pipeline for the same instruction stream. Program order and back-pressure are kept.

Every record passes through a single holding slot and a registered output stage. A compare or load in the holding slot is a fusion candidate, and it waits for its successor. It leaves alone only if its successor does not pair with it, if its own end-of-stream flag is set, or if the `drain` input is raised. Fusion is active only while `fuse_en` is high and `long_mode` is low. Fused outputs are marked on `out_fused` so that a downstream statistics counter can count them.

Top module: `cmp_branch_fuser`

## Requirements
- R1: Class codes are OTHER=0, CMP=1, JCC=2, LOAD=3, ADD=4, fused compare-branch=5 and fused load-add=6. A CMP followed at once by a JCC is emitted as one class-5 operation. Its src1 and src2 come from the compare, its cond and tgt come from the jump, its dst is 0, and its last flag is the OR of both last flags.
- R2: A compare with its memory flag set is still fused, and the class-5 output keeps mem=1.
- R3: A LOAD with mem=1 followed by an ADD whose src1 equals the load's dst is emitted as one class-6 operation. Its fields are dst taken from the add, src1 taken from the load (the address base), src2 taken from the add, mem=1, cond=0, and tgt taken from the load. If src1 does not match the load's dst, both records pass through unchanged.
- R4: A record that is not part of a fused pair is output bit-for-bit unchanged. Output order always equals input order.
- R5: A CMP or LOAD candidate whose last flag is clear produces no output while no successor is offered. It is released unchanged by `drain`. A candidate with its last flag set is emitted without waiting.
- R6: No fusion occurs when `fuse_en` is 0 or `long_mode` is 1. Every record then passes through unchanged.
- R7: `out_fused` is 1 exactly on outputs of class 5 or 6.
- R8: While `out_valid` is high and `out_ready` is low, all outputs hold their values. No record is lost or duplicated, and at most one operation is output per cycle.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: A stream of k back-to-back compare/jump pairs yields exactly k output operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_en | input | 1 | Enables fusion |
| long_mode | input | 1 | 64-bit mode; suppresses fusion |
| drain | input | 1 | Releases a waiting candidate alone |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted when high with in_valid |
| in_cls | input | 3 | Operation class code |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_mem | input | 1 | Memory operand flag |
| in_cond | input | 4 | Condition code |
| in_tgt | input | 16 | Target or displacement |
| in_last | input | 1 | End-of-stream flag |
| out_valid | output | 1 | Output operation valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_cls | output | 3 | Output class code |
| out_dst | output | 4 | Output destination register |
| out_src1 | output | 4 | Output first source |
| out_src2 | output | 4 | Output second source |
| out_mem | output | 1 | Output memory flag |
| out_cond | output | 4 | Output condition code |
| out_tgt | output | 16 | Output target or displacement |
| out_last | output | 1 | Output end-of-stream flag |
| out_fused | output | 1 | Output is a fused operation |

## Verification
Some properties are checked by the assertions on every cycle. The output stays stable under back-pressure. A record is never accepted into a full holding slot unless the slot empties in the same cycle. A waiting candidate stays put until it gets a successor or a drain. The fused flag agrees with the fused class codes, and no pair is fused while fusion is suppressed. Other behaviour can only be shown by the bench's scenarios: the exact contents of the merged fields, the register-match rule for load-add pairs, output order across mixed streams, and the drop from k pairs to k operations.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int CLS_W  = 3;
  localparam int REG_W  = 4;
  localparam int COND_W = 4;
  localparam int TGT_W  = 16;

  typedef enum logic [CLS_W-1:0] {
    CL_OTHER = 3'd0,
    CL_CMP   = 3'd1,
    CL_JCC   = 3'd2,
    CL_LOAD  = 3'd3,
    CL_ADD   = 3'd4,
    CL_FCJ   = 3'd5,
    CL_FLA   = 3'd6
  } cls_e;

  typedef enum logic [1:0] {PK_NONE, PK_CJ, PK_LA} pair_e;

  typedef struct packed {
    cls_e              cls;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  s1;
    logic [REG_W-1:0]  s2;
    logic              mem;
    logic [COND_W-1:0] cond;
    logic [TGT_W-1:0]  tgt;
    logic              last;
  } insn_t;

  // A record that may head a fused pair.
  function automatic logic is_candidate(insn_t h);
    return (h.cls == CL_CMP || (h.cls == CL_LOAD && h.mem)) && !h.last;
  endfunction

  function automatic pair_e pair_kind(insn_t h, insn_t n);
    if (h.cls == CL_CMP && n.cls == CL_JCC)
      return PK_CJ;
    if (h.cls == CL_LOAD && h.mem && n.cls == CL_ADD && n.s1 == h.dst)
      return PK_LA;
    return PK_NONE;
  endfunction

  function automatic insn_t merge_pair(insn_t h, insn_t n, pair_e k);
    insn_t r;
    r = h;
    if (k == PK_CJ) begin
      r.cls  = CL_FCJ;
      r.dst  = '0;
      r.cond = n.cond;
      r.tgt  = n.tgt;
    end else if (k == PK_LA) begin
      r.cls  = CL_FLA;
      r.dst  = n.dst;
      r.s2   = n.s2;
      r.mem  = 1'b1;
      r.cond = '0;
    end
    r.last = h.last | n.last;
    return r;
  endfunction
endpackage

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
  import fuse_pkg::*;
(
  input  logic  fuse_on,
  input  logic  head_v,
  input  insn_t head,
  input  logic  next_v,
  input  insn_t next,
  output pair_e kind,
  output logic  hold
);
  logic head_cand;

  always_comb begin
    head_cand = fuse_on && head_v && is_candidate(head);
    hold      = head_cand;
    kind      = PK_NONE;
    if (head_cand && next_v)
      kind = pair_kind(head, next);
  end
endmodule

// File: rtl/fuse_merge.sv
module fuse_merge
  import fuse_pkg::*;
(
  input  insn_t head,
  input  insn_t next,
  input  pair_e kind,
  output insn_t merged
);
  always_comb merged = merge_pair(head, next, kind);
endmodule

// File: rtl/cmp_branch_fuser.sv
module cmp_branch_fuser
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fuse_en,
  input  logic              long_mode,
  input  logic              drain,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  input  logic              in_mem,
  input  logic [COND_W-1:0] in_cond,
  input  logic [TGT_W-1:0]  in_tgt,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_cls,
  output logic [REG_W-1:0]  out_dst,
  output logic [REG_W-1:0]  out_src1,
  output logic [REG_W-1:0]  out_src2,
  output logic              out_mem,
  output logic [COND_W-1:0] out_cond,
  output logic [TGT_W-1:0]  out_tgt,
  output logic              out_last,
  output logic              out_fused
);
  insn_t in_rec, h_rec, o_rec, merged;
  logic  h_v, o_v, o_fused;
  pair_e kind;
  logic  hold, fuse_on;

  // Named internal events
  logic o_free, accept, take_pair, emit;

  always_comb begin
    in_rec.cls  = cls_e'(in_cls);
    in_rec.dst  = in_dst;
    in_rec.s1   = in_src1;
    in_rec.s2   = in_src2;
    in_rec.mem  = in_mem;
    in_rec.cond = in_cond;
    in_rec.tgt  = in_tgt;
    in_rec.last = in_last;
  end

  assign fuse_on = fuse_en && !long_mode;

  fuse_pair_detect u_detect (
    .fuse_on (fuse_on),
    .head_v  (h_v),
    .head    (h_rec),
    .next_v  (in_valid),
    .next    (in_rec),
    .kind    (kind),
    .hold    (hold)
  );

  fuse_merge u_merge (
    .head   (h_rec),
    .next   (in_rec),
    .kind   (kind),
    .merged (merged)
  );

  assign o_free    = !o_v || out_ready;
  assign in_ready  = !h_v || o_free;
  assign accept    = in_valid && in_ready;
  assign take_pair = h_v && o_free && in_valid && (kind != PK_NONE);
  assign emit      = h_v && o_free && (take_pair || !hold || in_valid || drain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_v     <= 1'b0;
      h_rec   <= '0;
      o_v     <= 1'b0;
      o_rec   <= '0;
      o_fused <= 1'b0;
    end else begin
      if (emit) begin
        o_v     <= 1'b1;
        o_rec   <= take_pair ? merged : h_rec;
        o_fused <= take_pair;
      end else if (out_ready) begin
        o_v <= 1'b0;
      end
      if (take_pair) begin
        h_v <= 1'b0;
      end else if (accept) begin
        h_v   <= 1'b1;
        h_rec <= in_rec;
      end else if (emit) begin
        h_v <= 1'b0;
      end
    end
  end

  assign out_valid = o_v;
  assign out_cls   = o_rec.cls;
  assign out_dst   = o_rec.dst;
  assign out_src1  = o_rec.s1;
  assign out_src2  = o_rec.s2;
  assign out_mem   = o_rec.mem;
  assign out_cond  = o_rec.cond;
  assign out_tgt   = o_rec.tgt;
  assign out_last  = o_rec.last;
  assign out_fused = o_fused;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(o_rec) && $stable(out_fused)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && h_v) |-> emit);

  // R5
  cand_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_v && hold && !in_valid && !drain) |=> (h_v && $stable(h_rec)));

  // R6
  fuse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_pair |-> (fuse_en && !long_mode));

  // R7
  fused_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fused == (out_cls == 3'd5 || out_cls == 3'd6)));
endmodule

// File: tb/cmp_branch_fuser_test.sv
module cmp_branch_fuser_test;
  localparam int W = 37;
  typedef logic [W-1:0] word_t;

  typedef struct packed {
    logic [2:0] ac; logic [3:0] ad, as1, as2; logic am;
    logic [2:0] bc; logic [3:0] bd, bs1, bs2, bcond; logic [7:0] btgt;
    logic en, lm, expf;
  } row_t;

  localparam int NROW = 10;
  localparam row_t ROWS [NROW] = '{
    '{3'd1, 4'd0, 4'd1, 4'd2, 1'b0, 3'd2, 4'd0, 4'd0, 4'd0, 4'd3, 8'h40, 1'b1, 1'b0, 1'b1},
    '{3'd1, 4'd0, 4'd3, 4'd4, 1'b1, 3'd2, 4'd0, 4'd0, 4'd0, 4'd5, 8'h41, 1'b1, 1'b0, 1'b1},
    '{3'd1, 4'd0, 4'd1, 4'd2, 1'b0, 3'd4, 4'd6, 4'd7, 4'd8, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{3'd1, 4'd0, 4'd1, 4'd2, 1'b0, 3'd2, 4'd0, 4'd0, 4'd0, 4'd3, 8'h42, 1'b0, 1'b0, 1'b0},
    '{3'd1, 4'd0, 4'd1, 4'd2, 1'b0, 3'd2, 4'd0, 4'd0, 4'd0, 4'd3, 8'h43, 1'b1, 1'b1, 1'b0},
    '{3'd3, 4'd5, 4'd6, 4'd0, 1'b1, 3'd4, 4'd7, 4'd5, 4'd8, 4'd0, 8'h00, 1'b1, 1'b0, 1'b1},
    '{3'd3, 4'd5, 4'd6, 4'd0, 1'b1, 3'd4, 4'd7, 4'd9, 4'd8, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{3'd0, 4'd1, 4'd2, 4'd3, 1'b0, 3'd2, 4'd0, 4'd0, 4'd0, 4'd3, 8'h44, 1'b1, 1'b0, 1'b0},
    '{3'd3, 4'd5, 4'd6, 4'd0, 1'b1, 3'd4, 4'd7, 4'd5, 4'd8, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0},
    '{3'd2, 4'd0, 4'd0, 4'd0, 1'b0, 3'd1, 4'd0, 4'd1, 4'd2, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, fuse_en, long_mode, drain, in_valid, in_ready, out_valid, out_ready, out_fused;
  logic [2:0] in_cls, out_cls;
  logic [3:0] in_dst, in_src1, in_src2, in_cond, out_dst, out_src1, out_src2, out_cond;
  logic [15:0] in_tgt, out_tgt;
  logic in_mem, in_last, out_mem, out_last;
  word_t drv, out_word;
  logic bp;
  int bpc;

  int errors = 0;
  int nchecks = 0;
  word_t cap [64];
  logic capf [64];
  int ncap;
  logic acc;
  logic pv, pr, pf;
  word_t pw;

  always #5 clk = ~clk;

  assign {in_cls, in_dst, in_src1, in_src2, in_mem, in_cond, in_tgt, in_last} = drv;
  assign out_word = {out_cls, out_dst, out_src1, out_src2, out_mem, out_cond, out_tgt, out_last};

  cmp_branch_fuser uut (
    .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en), .long_mode(long_mode), .drain(drain),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_mem(in_mem), .in_cond(in_cond),
    .in_tgt(in_tgt), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_cls(out_cls), .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
    .out_mem(out_mem), .out_cond(out_cond), .out_tgt(out_tgt), .out_last(out_last),
    .out_fused(out_fused)
  );

  // Downstream readiness: always ready, or ready one cycle in three under back-pressure.
  always @(negedge clk) begin
    bpc = (bpc == 2) ? 0 : bpc + 1;
    out_ready = !bp || (bpc == 0);
  end

  function automatic word_t mk(logic [2:0] c, logic [3:0] d, logic [3:0] s1, logic [3:0] s2,
                               logic m, logic [3:0] cd, logic [15:0] t, logic l);
    return {c, d, s1, s2, m, cd, t, l};
  endfunction

  task automatic chk(logic ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
  endtask

  task automatic tick();
    #1;
    acc = in_valid && in_ready;
    if (out_valid && out_ready && ncap < 64) begin
      cap[ncap]  = out_word;
      capf[ncap] = out_fused;
      ncap++;
    end
    if (pv && !pr)
      chk(out_valid && out_word == pw && out_fused == pf, "R8", "output moved while stalled",
          64'(out_word), 64'(pw));
    pv = out_valid; pr = out_ready; pw = out_word; pf = out_fused;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(word_t x);
    int guard;
    guard = 0;
    drv = x;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc && guard < 1000) begin
      tick();
      guard++;
    end
    if (!acc) chk(1'b0, "R8", "input never accepted", 64'(guard), 64'(0));
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    nchecks++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    word_t a, b, e, c1, j1, o1, o2;
    rst_n = 1'b0; fuse_en = 1'b1; long_mode = 1'b0; drain = 1'b0;
    in_valid = 1'b0; drv = '0; bp = 1'b0; bpc = 0;
    ncap = 0; pv = 1'b0; pr = 1'b1; pf = 1'b0; pw = '0; acc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'(0));
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'(1));
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = ROWS[i];
      fuse_en = r.en;
      long_mode = r.lm;
      ncap = 0;
      a = mk(r.ac, r.ad, r.as1, r.as2, r.am, 4'd0, 16'h0100 + 16'(i), 1'b0);
      b = mk(r.bc, r.bd, r.bs1, r.bs2, 1'b0, r.bcond, {8'h00, r.btgt}, 1'b1);
      send(a);
      send(b);
      repeat (4) tick();
      if (r.expf) begin
        if (r.ac == 3'd1)
          e = mk(3'd5, 4'd0, r.as1, r.as2, r.am, r.bcond, {8'h00, r.btgt}, 1'b1);
        else
          e = mk(3'd6, r.bd, r.as1, r.bs2, 1'b1, 4'd0, 16'h0100 + 16'(i), 1'b1);
        chk(ncap == 1, "R1/R3/R10", $sformatf("row %0d fused count", i), 64'(ncap), 64'(1));
        chk(cap[0] == e, "R1/R2/R3", $sformatf("row %0d fused record", i), 64'(cap[0]), 64'(e));
        chk(capf[0] == 1'b1, "R7", $sformatf("row %0d fused flag", i), 64'(capf[0]), 64'(1));
      end else begin
        chk(ncap == 2, "R4/R6", $sformatf("row %0d pass count", i), 64'(ncap), 64'(2));
        chk(cap[0] == a, "R4/R6", $sformatf("row %0d first record", i), 64'(cap[0]), 64'(a));
        chk(cap[1] == b, "R4/R6", $sformatf("row %0d second record", i), 64'(cap[1]), 64'(b));
        chk(capf[0] == 1'b0 && capf[1] == 1'b0, "R7", $sformatf("row %0d flags", i),
            64'({capf[0], capf[1]}), 64'(0));
      end
    end
    fuse_en = 1'b1;
    long_mode = 1'b0;

    // R5 candidate waits for its successor, then fuses
    ncap = 0;
    c1 = mk(3'd1, 4'd0, 4'd1, 4'd2, 1'b0, 4'd0, 16'h0000, 1'b0);
    j1 = mk(3'd2, 4'd0, 4'd0, 4'd0, 1'b0, 4'd7, 16'h1234, 1'b1);
    send(c1);
    repeat (5) tick();
    chk(ncap == 0, "R5", "candidate emitted early", 64'(ncap), 64'(0));
    send(j1);
    repeat (4) tick();
    e = mk(3'd5, 4'd0, 4'd1, 4'd2, 1'b0, 4'd7, 16'h1234, 1'b1);
    chk(ncap == 1 && cap[0] == e, "R5", "late jump fused", 64'(cap[0]), 64'(e));

    // R5 drain releases a waiting candidate unchanged
    ncap = 0;
    send(c1);
    repeat (3) tick();
    chk(ncap == 0, "R5", "candidate emitted before drain", 64'(ncap), 64'(0));
    drain = 1'b1;
    tick();
    drain = 1'b0;
    repeat (3) tick();
    chk(ncap == 1 && cap[0] == c1 && capf[0] == 1'b0, "R5", "drained compare",
        64'(cap[0]), 64'(c1));

    // R8 back-pressure with a mixed stream, order kept (R4)
    ncap = 0;
    bp = 1'b1;
    o1 = mk(3'd0, 4'd1, 4'd2, 4'd3, 1'b0, 4'd0, 16'h0001, 1'b0);
    o2 = mk(3'd0, 4'd4, 4'd5, 4'd6, 1'b1, 4'd0, 16'h0002, 1'b1);
    j1 = mk(3'd2, 4'd0, 4'd0, 4'd0, 1'b0, 4'd9, 16'h0abc, 1'b0);
    send(o1);
    send(c1);
    send(j1);
    send(o2);
    repeat (12) tick();
    bp = 1'b0;
    repeat (3) tick();
    e = mk(3'd5, 4'd0, 4'd1, 4'd2, 1'b0, 4'd9, 16'h0abc, 1'b0);
    chk(ncap == 3, "R8", "stalled stream count", 64'(ncap), 64'(3));
    chk(cap[0] == o1, "R4", "stalled stream first", 64'(cap[0]), 64'(o1));
    chk(cap[1] == e && capf[1], "R8", "stalled stream fused", 64'(cap[1]), 64'(e));
    chk(cap[2] == o2, "R4", "stalled stream last", 64'(cap[2]), 64'(o2));

    // R10 three back-to-back pairs give three operations
    ncap = 0;
    for (int k = 0; k < 3; k++) begin
      send(mk(3'd1, 4'd0, 4'(k), 4'(k + 1), 1'b0, 4'd0, 16'h0000, 1'b0));
      send(mk(3'd2, 4'd0, 4'd0, 4'd0, 1'b0, 4'(k), 16'(k), k == 2));
    end
    repeat (4) tick();
    chk(ncap == 3, "R10", "pair stream op count", 64'(ncap), 64'(3));
    chk(capf[0] && capf[1] && capf[2], "R10", "pair stream flags",
        64'({capf[0], capf[1], capf[2]}), 64'(7));

    summary();
    $finish;
  end
endmodule